// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one logic cell of the kind found in an erasable programmable logic device. A programmable AND array builds product terms over a small set of array inputs plus one feedback signal. Eight of these terms are ORed into a sum, which can be inverted. Three more terms each have a fixed job: one drives the pin output enable, one can serve as a local clock, and one clears the storage element. The sum goes to a storage element that can act as a D or a T flip-flop and can trigger on a rising or a falling edge. The selected value, either the stored bit or the raw sum, drives a pad that is modelled as a value plus an enable.

All configuration arrives as static input bits. The block runs on one system clock `clk`. Both clock sources for the storage element are sampled on `clk`: the global cell clock `gclk` and the product-term clock. An edge of the selected polarity on the selected source acts as a one-cycle clock enable for the storage element. There is no streaming data path, so all pins are plain level signals with no valid/ready handshake.

Top module: `mc_macrocell`

## Requirements
- R1: Term t reads the array vector {feedback, arr_in}, with feedback at bit N_IN. It uses bits cfg_inc[t*W +: W] and cfg_inv[t*W +: W], where W = N_IN+1. The term is the AND of every included bit, and a bit is complemented when its invert bit is 1. A term with no included bits is 0.
- R2: The sum is the OR of terms 0 to 7. It is XORed with cfg_pol before it reaches the storage element and the output selector.
- R3: With cfg_out_reg=0, pad_o follows the inverted-or-not sum in the same cycle. With cfg_out_reg=1, pad_o shows the stored bit.
- R4: The feedback bit is the stored bit when cfg_fb_reg=1 and pad_i when cfg_fb_reg=0.
- R5: In D mode (cfg_tff=0), a clock event at a clk rising edge loads the sum into the stored bit at that same edge. Without an event or a clear, the stored bit holds.
- R6: In T mode (cfg_tff=1), a clock event inverts the stored bit when the sum is 1 and leaves it unchanged when the sum is 0.
- R7: The clock source is gclk when cfg_ptclk=0 and term 9 when cfg_ptclk=1.
- R8: A clock event is a change of the source between consecutive clk samples. It is a 0-to-1 change when cfg_neg=0 and a 1-to-0 change when cfg_neg=1.
- R9: When term 10 is 1 at a clk edge, the stored bit becomes 0, whatever the clock event.
- R10: pad_oe equals term 8, and it is 0 whenever rst is high.
- R11: A synchronous rst clears the stored bit and sets the remembered previous clock source sample to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_in | input | N_IN | Array input signals |
| gclk | input | 1 | Global cell clock, sampled on clk |
| pad_i | input | 1 | Value seen on the pad |
| cfg_inc | input | NT*W | Include bits, W per term |
| cfg_inv | input | NT*W | Complement bits, W per term |
| cfg_pol | input | 1 | Invert the sum |
| cfg_tff | input | 1 | 1 selects T behaviour, 0 selects D |
| cfg_neg | input | 1 | 1 selects falling-edge trigger |
| cfg_ptclk | input | 1 | 1 selects product-term clock |
| cfg_out_reg | input | 1 | 1 drives the stored bit to the pad |
| cfg_fb_reg | input | 1 | 1 feeds back the stored bit |
| pad_o | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |

## Verification
The sum path and the output enable are combinational. The bench therefore checks them about 1 ns after it drives inputs at a falling clk edge, with no clock edge in between. A clock event and a clear both take effect at the first rising clk edge that samples them. For this reason every sequential check comes 1 ns after the rising edge that follows the stimulus. That check compares against a bench model which updates at the same edge. The output enable is checked again after that edge, because the new stored bit can change it through feedback.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic pol;
    logic tff;
    logic neg;
    logic ptclk;
    logic out_reg;
    logic fb_reg;
  } mc_mode_t;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} mc_edge_e;

  function automatic int unsigned term_oe(input int unsigned n_sum);
    return n_sum;
  endfunction

  function automatic int unsigned term_clk(input int unsigned n_sum);
    return n_sum + 1;
  endfunction

  function automatic int unsigned term_clr(input int unsigned n_sum);
    return n_sum + 2;
  endfunction
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] inv,
  output logic         hit
);
  logic [W-1:0] lit;
  always_comb begin
    lit = (vec ^ inv) | ~inc;
    hit = (|inc) & (&lit);
  end
endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
  import mc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gclk,
  input  logic pt_clk,
  input  logic sel_pt,
  input  logic neg,
  output logic tick
);
  logic src, prev_r;
  mc_edge_e pol;

  always_comb begin
    src  = sel_pt ? pt_clk : gclk;
    pol  = neg ? EDGE_FALL : EDGE_RISE;
    tick = (pol == EDGE_FALL) ? (prev_r & ~src) : (~prev_r & src);
  end

  always_ff @(posedge clk) begin
    if (rst) prev_r <= 1'b0;
    else     prev_r <= src;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  input  logic tff,
  input  logic d,
  output logic q
);
  logic nxt;
  always_comb begin
    nxt = q;
    if (clr)       nxt = 1'b0;
    else if (tick) nxt = tff ? (q ^ d) : d;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_SUM = 8,
  parameter int unsigned W     = N_IN + 1,
  parameter int unsigned NT    = N_SUM + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] arr_in,
  input  logic            gclk,
  input  logic            pad_i,
  input  logic [NT*W-1:0] cfg_inc,
  input  logic [NT*W-1:0] cfg_inv,
  input  logic            cfg_pol,
  input  logic            cfg_tff,
  input  logic            cfg_neg,
  input  logic            cfg_ptclk,
  input  logic            cfg_out_reg,
  input  logic            cfg_fb_reg,
  output logic            pad_o,
  output logic            pad_oe
);
  localparam int unsigned T_OE  = term_oe(N_SUM);
  localparam int unsigned T_CLK = term_clk(N_SUM);
  localparam int unsigned T_CLR = term_clr(N_SUM);

  mc_mode_t     mode;
  logic         q_r;
  logic         fb;
  logic [W-1:0] vec;
  logic [NT-1:0] terms;
  logic         sum_val;
  logic         ff_tick;
  logic         clr_hit;

  always_comb begin
    mode = '{pol: cfg_pol, tff: cfg_tff, neg: cfg_neg, ptclk: cfg_ptclk,
             out_reg: cfg_out_reg, fb_reg: cfg_fb_reg};
    fb   = mode.fb_reg ? q_r : pad_i;
    vec  = {fb, arr_in};
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    mc_pterm #(.W(W)) u_pt (
      .vec(vec),
      .inc(cfg_inc[t*W +: W]),
      .inv(cfg_inv[t*W +: W]),
      .hit(terms[t])
    );
  end

  always_comb begin
    sum_val = (|terms[N_SUM-1:0]) ^ mode.pol;
    clr_hit = terms[T_CLR];
  end

  mc_clk_sel u_clk (
    .clk(clk), .rst(rst), .gclk(gclk), .pt_clk(terms[T_CLK]),
    .sel_pt(mode.ptclk), .neg(mode.neg), .tick(ff_tick)
  );

  mc_store u_ff (
    .clk(clk), .rst(rst), .tick(ff_tick), .clr(clr_hit),
    .tff(mode.tff), .d(sum_val), .q(q_r)
  );

  always_comb begin
    pad_o  = mode.out_reg ? q_r : sum_val;
    pad_oe = ~rst & terms[T_OE];
  end
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic clk,
  input logic rst,
  input logic tff,
  input logic tick,
  input logic clr,
  input logic sum,
  input logic q,
  input logic oe
);
  assert_oe_reset_R10: assert property (@(posedge clk) rst |-> !oe);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(q));
  assert_dload_R5: assert property (@(posedge clk) disable iff (rst)
    (!tff && tick && !clr) |=> (q == $past(sum)));
  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (tff && tick && !clr) |=> (q == ($past(q) ^ $past(sum))));
endmodule

bind mc_macrocell mc_checker u_chk (
  .clk(clk), .rst(rst), .tff(cfg_tff), .tick(ff_tick), .clr(clr_hit),
  .sum(sum_val), .q(q_r), .oe(pad_oe)
);

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;
  localparam int N_IN = 4;
  localparam int W    = N_IN + 1;
  localparam int NT   = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] arr_in = '0;
  logic gclk = 1'b0, pad_i = 1'b0;
  logic [NT*W-1:0] inc = '0, inv = '0;
  logic pol = 0, tff = 0, neg = 0, ptclk = 0, out_reg = 0, fb_reg = 0;
  logic pad_o, pad_oe;

  int total = 0, bad = 0, cyc = 0;
  logic exp_q = 1'b0, prev = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  mc_macrocell u0 (
    .clk(clk), .rst(rst), .arr_in(arr_in), .gclk(gclk), .pad_i(pad_i),
    .cfg_inc(inc), .cfg_inv(inv), .cfg_pol(pol), .cfg_tff(tff),
    .cfg_neg(neg), .cfg_ptclk(ptclk), .cfg_out_reg(out_reg),
    .cfg_fb_reg(fb_reg), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic term(input int t, input logic [W-1:0] v);
    logic [W-1:0] m = inc[t*W +: W];
    logic [W-1:0] n = inv[t*W +: W];
    if (m == '0) return 1'b0;
    for (int j = 0; j < W; j++)
      if (m[j] && (v[j] == n[j])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] cur_vec();
    return {fb_reg ? exp_q : pad_i, arr_in};
  endfunction

  function automatic logic exp_sum();
    logic s = 1'b0;
    for (int t = 0; t < 8; t++) s |= term(t, cur_vec());
    return s ^ pol;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    #1 check("R10", pad_oe, 1'b0);
    @(negedge clk) rst = 1'b0;
    exp_q = 1'b0; prev = 1'b0;
  endtask

  // called just after a negedge with inputs already set
  task automatic clock_step(input string tag);
    logic [W-1:0] v;
    logic src, ev, nq;
    #1;
    v   = cur_vec();
    src = ptclk ? term(9, v) : gclk;
    ev  = neg ? (prev & ~src) : (~prev & src);
    nq  = exp_q;
    if (term(10, v))  nq = 1'b0;
    else if (ev)      nq = tff ? (exp_q ^ exp_sum()) : exp_sum();
    @(posedge clk);
    #1;
    exp_q = nq; prev = src;
    check(tag, pad_o, exp_q);
    check("R10", pad_oe, term(8, cur_vec()));
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] lit(input int j);
    return W'(1) << j;
  endfunction

  initial begin
    // reset state, R10 and R11
    out_reg = 1; inc[8*W +: W] = lit(0); arr_in = 4'b0001;
    @(negedge clk); #1;
    check("R10", pad_oe, 1'b0);
    do_reset();
    #1 check("R10", pad_oe, 1'b1);
    check("R11", pad_o, 1'b0);

    // R1: an all-excluded term is 0 regardless of polarity path
    out_reg = 0; inc = '0; inv = '1; pol = 0;
    @(negedge clk); #1 check("R1", pad_o, 1'b0);
    pol = 1;
    #1 check("R1", pad_o, 1'b1);

    // R1..R4 combinational sweep over array inputs and pad_i
    for (int c = 0; c < 24; c++) begin
      seed = rnd(seed); inc = {seed, rnd(seed)}; seed = rnd(seed);
      inv = {seed, rnd(seed)}; seed = rnd(seed);
      for (int t = 0; t < NT; t++)
        if (seed[t]) inc[t*W +: W] &= rnd(seed + t);
      pol = c[0]; fb_reg = c[1]; out_reg = 0; ptclk = 0; gclk = 0;
      do_reset();
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        arr_in = p[3:0]; pad_i = p[4];
        #1;
        exp_q = 1'b0;
        check(fb_reg ? "R4" : "R2", pad_o, exp_sum());
        check("R10", pad_oe, term(8, cur_vec()));
      end
    end

    // directed: D on rising gclk, R5 and R3 (registered path)
    inc = '0; inv = '0; pol = 0; tff = 0; neg = 0; ptclk = 0;
    out_reg = 1; fb_reg = 1; gclk = 0;
    inc[0 +: W] = lit(0); inc[10*W +: W] = lit(1);
    do_reset();
    arr_in = 4'b0001;                       clock_step("R5");
    check("R5", pad_o, 1'b0);
    gclk = 1;                               clock_step("R5");
    check("R3", pad_o, 1'b1);
    arr_in = 4'b0000;                       clock_step("R5");
    gclk = 0;                               clock_step("R8");
    check("R8", pad_o, 1'b1);
    gclk = 1;                               clock_step("R5");
    check("R5", pad_o, 1'b0);
    // clear wins over a load, R9
    gclk = 0; arr_in = 4'b0001;             clock_step("R9");
    gclk = 1;                               clock_step("R9");
    gclk = 0; arr_in = 4'b0011;             clock_step("R9");
    check("R9", pad_o, 1'b0);
    gclk = 1;                               clock_step("R9");
    check("R9", pad_o, 1'b0);

    // sweep of storage modes with model tracking
    for (int m = 0; m < 16; m++) begin
      seed = rnd(seed); inc = {seed, rnd(seed)}; seed = rnd(seed);
      inv = {seed, rnd(seed)};
      inc[10*W +: W] = lit(0) | lit(1) | lit(2);
      inc[9*W +: W]  = lit(3);
      tff = m[0]; neg = m[1]; ptclk = m[2]; fb_reg = m[3];
      pol = 0; out_reg = 1;
      do_reset();
      for (int s = 0; s < 48; s++) begin
        seed = rnd(seed);
        arr_in = seed[3:0]; pad_i = seed[4]; gclk = seed[5];
        clock_step(ptclk ? "R7" : (neg ? "R8" : (tff ? "R6" : "R5")));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=200000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule